// File: doc/BRIEF.md
# Multi-Bank Phase-Aligned Clock Divider

This block takes one input clock and produces three output banks. Each bank carries a divided copy of that clock, and each bank has its own select input that chooses between two divide ratios. The first bank either passes the clock through or halves it. The second and third banks either halve it or quarter it. All banks run from one shared 2-bit phase counter, so every output that is running rises on the same input clock edge.

An active-low master reset forces every output low at once and holds it low. The master reset is asynchronous on assertion and is released in step with the clock. The enable input is asynchronous. It passes through a synchroniser and is applied only at the boundary where the shared counter wraps. Outputs therefore start and stop in phase and never produce a shortened pulse. A select change is also held back to that boundary. The pass-through path is gated by a latch that is open while the clock is low, so a gated clock pulse is never cut short.

Top module: `phase_aligned_clkdiv`

## Requirements
- R1: With `bank0_sel_i` = 0, `bank0_clk_o` follows the input clock (high during the high half, low during the low half). With `bank0_sel_i` = 1 it is the clock divided by 2: high for one cycle, low for one cycle.
- R2: For bank 1 and bank 2, select = 0 gives the clock divided by 2 (high 1 cycle, low 1 cycle). Select = 1 gives the clock divided by 4 (high 2 cycles, low 2 cycles).
- R3: While `rst_ni` is low, all three outputs are low. An output that is high goes low immediately when `rst_ni` falls, without waiting for a clock edge.
- R4: After `enable_i` rises, the first output high phase begins on an input clock rising edge between 2 and 6 edges after the change.
- R5: After `enable_i` falls, outputs keep running for at least the next 2 edges. From no later than the 6th edge they stay low.
- R6: Every running bank rises on the same input clock edge. That edge, counted as cycle 0, marks the 4-cycle boundary. The first pulse after a start has full width for its ratio.
- R7: After reset release with `enable_i` high, the outputs start within 8 input clock edges, in phase and with full-width pulses.
- R8: A select change takes effect only at the next 4-cycle boundary. The old ratio continues until then, so no pulse is shortened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous active-low master reset |
| enable_i | input | 1 | Asynchronous output enable, active high |
| bank0_sel_i | input | 1 | Bank 0 ratio: 0 = pass-through, 1 = divide by 2 |
| bank1_sel_i | input | 1 | Bank 1 ratio: 0 = divide by 2, 1 = divide by 4 |
| bank2_sel_i | input | 1 | Bank 2 ratio: 0 = divide by 2, 1 = divide by 4 |
| bank0_clk_o | output | 1 | Bank 0 clock output |
| bank1_clk_o | output | 1 | Bank 1 clock output |
| bank2_clk_o | output | 1 | Bank 2 clock output |

## Verification
If the shared phase counter or an output register holds a wrong value, the banks stop rising together. A divide-by-4 output then shows a high time other than two cycles, and this is visible at the ports within one 4-cycle wrap. If the aligned enable is stuck or updates off the boundary, the start or stop latency falls outside its window, or a first pulse is short; this shows within six edges of an enable change. A select register that updates early shows at once as a broken pattern in the two edges before the boundary.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int PHASE_W = 2;
  typedef logic [PHASE_W-1:0] phase_t;
endpackage

// File: rtl/clkdiv_rst_sync.sv
module clkdiv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_sync_no = chain_q[STAGES-1];
endmodule

// File: rtl/clkdiv_phase_ctrl.sv
module clkdiv_phase_ctrl
  import clkdiv_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  output logic wrap_o,
  output logic tap1_o,
  output logic tap2_o,
  output logic tap4_o
);
  localparam phase_t PHASE_LAST = '1;

  logic [SYNC_STAGES-1:0] en_sync_q, en_sync_d;
  logic   en_s;
  phase_t phase_q, phase_d;
  logic   en_aln_q, en_aln_d;
  logic   div2_q, div2_d, div4_q, div4_d;
  logic   gate_l;
  logic   wrap;

  // next-state logic
  always_comb begin
    en_sync_d = {en_sync_q[SYNC_STAGES-2:0], enable_i};
    en_s      = en_sync_q[SYNC_STAGES-1];
    wrap      = (phase_q == PHASE_LAST);
    phase_d   = phase_q + phase_t'(1);
    en_aln_d  = wrap ? en_s : en_aln_q;
    div2_d    = en_aln_d & ~phase_d[0];
    div4_d    = en_aln_d & ~phase_d[PHASE_W-1];
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_sync_q <= '0;
      phase_q   <= '0;
      en_aln_q  <= 1'b0;
      div2_q    <= 1'b0;
      div4_q    <= 1'b0;
    end else begin
      en_sync_q <= en_sync_d;
      phase_q   <= phase_d;
      en_aln_q  <= en_aln_d;
      div2_q    <= div2_d;
      div4_q    <= div4_d;
    end
  end

  // gate for the pass-through path: open only while the clock is low
  always_latch begin
    if (!rst_ni)     gate_l = 1'b0;
    else if (!clk_i) gate_l = en_aln_d;
  end

  assign wrap_o = wrap;
  assign tap1_o = clk_i & gate_l;
  assign tap2_o = div2_q;
  assign tap4_o = div4_q;

  // R4 / R5: aligned enable moves only at the counter boundary
  p_enable_on_boundary_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(en_aln_q) |-> ($past(phase_q) == PHASE_LAST));

  // R6: a divide-by-4 rise is always a divide-by-2 rise as well
  p_common_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(div4_q) |-> $rose(div2_q));

  // R2: divide-by-4 high phase lasts two cycles, divide-by-2 goes low in between
  p_div4_width_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(div4_q) |=> (div4_q && !div2_q));

  // R5: when the aligned enable drops, both divided taps are already low
  p_stop_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_aln_q) |-> (!div2_q && !div4_q));
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wrap_i,
  input  logic sel_i,
  input  logic lo_tap_i,
  input  logic hi_tap_i,
  output logic clk_o
);
  logic sel_q, sel_d;

  always_comb begin
    sel_d = wrap_i ? sel_i : sel_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= 1'b0;
    else         sel_q <= sel_d;
  end

  assign clk_o = sel_q ? hi_tap_i : lo_tap_i;

  // R8: the registered ratio changes only after a boundary cycle
  p_sel_at_boundary_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sel_q) |-> $past(wrap_i));
endmodule

// File: rtl/phase_aligned_clkdiv.sv
module phase_aligned_clkdiv #(
  parameter int RST_STAGES  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic bank0_sel_i,
  input  logic bank1_sel_i,
  input  logic bank2_sel_i,
  output logic bank0_clk_o,
  output logic bank1_clk_o,
  output logic bank2_clk_o
);
  localparam int NBANK = 3;

  logic rst_sync_n;
  logic wrap, tap1, tap2, tap4;
  logic [NBANK-1:0] sel_v, lo_v, hi_v, out_v;

  clkdiv_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_sync_no(rst_sync_n)
  );

  clkdiv_phase_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .enable_i(enable_i),
    .wrap_o(wrap), .tap1_o(tap1), .tap2_o(tap2), .tap4_o(tap4)
  );

  assign sel_v = {bank2_sel_i, bank1_sel_i, bank0_sel_i};

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    if (b == 0) begin : g_fast
      assign lo_v[b] = tap1;
      assign hi_v[b] = tap2;
    end else begin : g_slow
      assign lo_v[b] = tap2;
      assign hi_v[b] = tap4;
    end
    clkdiv_bank u_bank (
      .clk_i(clk_i), .rst_ni(rst_sync_n), .wrap_i(wrap), .sel_i(sel_v[b]),
      .lo_tap_i(lo_v[b]), .hi_tap_i(hi_v[b]), .clk_o(out_v[b])
    );
  end

  assign bank0_clk_o = out_v[0];
  assign bank1_clk_o = out_v[1];
  assign bank2_clk_o = out_v[2];

  // R3: outputs sit low while master reset is held
  p_reset_low_r3: assert property (@(posedge clk_i)
    !rst_ni |-> (out_v == '0));
endmodule

// File: tb/phase_aligned_clkdiv_test.sv
`timescale 1ns/1ps
module phase_aligned_clkdiv_test;
  logic clk = 1'b0;
  logic rst_n, en, s0, s1, s2;
  logic o0, o1, o2;
  logic [2:0] hi, lo;
  int checks = 0, fails = 0, ecnt = 0, f_edge = 0;

  always #10 clk = ~clk;

  phase_aligned_clkdiv uut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en),
    .bank0_sel_i(s0), .bank1_sel_i(s1), .bank2_sel_i(s2),
    .bank0_clk_o(o0), .bank1_clk_o(o1), .bank2_clk_o(o2)
  );

  // {sel0, sel1, sel2, ratio0, ratio1, ratio2}; ratio code 0 = /1, 1 = /2, 2 = /4
  localparam logic [8:0] CFG [8] = '{
    9'b000_00_01_01, 9'b001_00_01_10, 9'b010_00_10_01, 9'b011_00_10_10,
    9'b100_01_01_01, 9'b101_01_01_10, 9'b110_01_10_01, 9'b111_01_10_10
  };

  function automatic logic expv(input int ratio, input int j, input bit high_half);
    if (ratio == 0) return high_half;
    if (ratio == 1) return (j % 2) == 0;
    return (j % 4) < 2;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at edge %0d: actual %b expected %b", req, ecnt, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #5 hi = {o2, o1, o0};
    #10 lo = {o2, o1, o0};
    ecnt++;
  endtask

  task automatic check_now(input string req, input int r0, input int r1, input int r2);
    int rr[3];
    int j;
    rr[0] = r0; rr[1] = r1; rr[2] = r2;
    j = ecnt - f_edge;
    for (int b = 0; b < 3; b++) begin
      check(req, hi[b], expv(rr[b], j, 1'b1));
      check(req, lo[b], expv(rr[b], j, 1'b0));
    end
  endtask

  task automatic run_pattern(input int n, input string req, input int r0, input int r1, input int r2);
    for (int k = 0; k < n; k++) begin
      step();
      check_now(req, r0, r1, r2);
    end
  endtask

  // wait for the first high output; returns edges waited
  task automatic wait_start(output int k);
    k = 0;
    do begin
      step();
      k++;
    end while ((hi | lo) == 3'b000 && k < 12);
    f_edge = ecnt;
  endtask

  initial begin
    int k, last;
    rst_n = 1'b0; en = 1'b1; s0 = 1'b1; s1 = 1'b1; s2 = 1'b1;
    // R3: held reset keeps all outputs low with the clock running
    for (int i = 0; i < 4; i++) begin
      step();
      check("R3 reset hold", |(hi | lo), 1'b0);
    end
    rst_n = 1'b1;
    // R7: start after reset release, aligned, full width
    wait_start(k);
    check("R7 start within 8 edges", (k <= 8), 1'b1);
    check_now("R7 first pulse", 1, 2, 2);
    run_pattern(8, "R7 pattern after reset", 1, 2, 2);
    en = 1'b0;
    for (int i = 0; i < 8; i++) step();

    // table walk: R1, R2, R4, R5, R6
    for (int c = 0; c < 8; c++) begin
      {s0, s1, s2} = CFG[c][8:6];
      en = 1'b1;
      wait_start(k);
      check("R4 enable latency in 2..6", (k >= 2 && k <= 6), 1'b1);
      check_now("R6 common first edge", int'(CFG[c][5:4]), int'(CFG[c][3:2]), int'(CFG[c][1:0]));
      run_pattern(15, "R1/R2 ratio pattern", int'(CFG[c][5:4]), int'(CFG[c][3:2]), int'(CFG[c][1:0]));
      en = 1'b0;
      last = 0;
      for (int i = 1; i <= 10; i++) begin
        step();
        if ((hi | lo) != 3'b000) last = i;
        if (CFG[c][8] == 1'b0 && i <= 2) check("R5 keeps running 2 edges", hi[0], 1'b1);
      end
      check("R5 stopped by edge 6", (last <= 5), 1'b1);
    end

    // R8: ratio change held to the boundary
    {s0, s1, s2} = 3'b000;
    en = 1'b1;
    wait_start(k);
    step();                       // j = 1
    s2 = 1'b1;
    step(); check("R8 old ratio j2", hi[2], 1'b1);
    step(); check("R8 old ratio j3", hi[2], 1'b0);
    step(); check("R8 new ratio j4", hi[2], 1'b1);
    step(); check("R8 new ratio j5", hi[2], 1'b1);
    step(); check("R8 new ratio j6", hi[2], 1'b0);
    step(); check("R8 new ratio j7", hi[2], 1'b0);
    check("R8 bank1 unchanged", hi[1], 1'b0);

    // R3: asynchronous reset while bank 0 is high
    @(posedge clk);
    #5 check("R3 bank0 high before reset", o0, 1'b1);
    rst_n = 1'b0;
    #1 check("R3 async reset", |{o2, o1, o0}, 1'b0);
    for (int i = 0; i < 3; i++) begin
      step();
      check("R3 reset hold", |(hi | lo), 1'b0);
    end
    {s0, s1, s2} = 3'b001;
    rst_n = 1'b1;
    wait_start(k);
    check("R7 restart within 8 edges", (k <= 8), 1'b1);
    check_now("R7 restart first pulse", 0, 1, 2);
    run_pattern(8, "R7 restart pattern", 0, 1, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails + 1);
    $finish;
  end
endmodule